// File: doc/BRIEF.md
# Multi-format serial audio port

This block is the master side of a stereo serial audio link to a codec. From the master clock it makes a bit clock and a frame clock. It shifts a left/right sample pair out on one data line and captures a pair from the codec's data line in the same frame. Each frame holds 64 bit-clock periods in two slots of 32. At run time a format code and a word-length code select how the words sit in their slots and what the frame clock looks like. The codes are taken only at a frame boundary, so a change never splits a frame.

The host side has one valid/ready pair per direction, and the left and right words travel together. On transmit a single holding entry accepts the next pair. That pair moves into the serializer at the next frame boundary. If the host misses a boundary, the last pair is sent again and a sticky flag records the gap. On receive the captured pair is presented once the last bit of the frame is in, and it stays presented until the host takes it.

Top module: `audio_serial_port`

## Requirements
- R1: With the default parameters the bit clock `bclk` is high for 2 and low for 2 master clocks, and a frame is 64 bit periods. `sdout` and `fclk` change only at falling bit-clock edges. While in reset, `bclk`, `fclk`, `sdout`, `rx_valid` and `underrun` are 0 and `tx_ready` is 1.
- R2: Format codes on `fmt_sel` are 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = two-slot TDM with a level frame clock, 4 = TDM with a pulse sync; codes 5 to 7 act as 0. In code 0, `fclk` is low during slot 0 (left) and high during slot 1 (right). In codes 1, 2 and 3 it is high during slot 0 and low during slot 1.
- R3: In I2S format a word starts MSB first one bit period after the slot's first bit period, i.e. at slot positions 1 to W.
- R4: In left-justified, TDM-level and pulse-TDM formats a word starts MSB first at slot position 0 and occupies positions 0 to W-1.
- R5: In right-justified format the LSB sits at slot position 31, so the word occupies positions 32-W to 31.
- R6: In pulse-TDM format `fclk` is high for exactly one bit period, the last period of a frame, which is the one just before slot 0's MSB of the next frame.
- R7: Word-length codes on `wlen_sel` are 0 = 16, 1 = 18, 2 = 20 and 3 = 24 bits. The word is the low W bits of the 24-bit sample. Every slot position outside the word is sent as 0, and sample bits above W are not sent.
- R8: `sdin` is sampled at rising bit-clock edges at the same positions as transmit. Each captured word is returned right-aligned with zeros above W, and bits at other positions are ignored. `rx_valid` rises after the last bit of a frame and stays high, with `rx_left`/`rx_right` unchanged, until a cycle with `rx_ready` high.
- R9: `tx_ready` is high while the single transmit holding entry is empty. An accepted pair is sent in the next frame after a frame boundary. `fmt_sel` and `wlen_sel` are sampled only at frame boundaries.
- R10: A handshake in the same master-clock cycle as a frame boundary, with the holding entry empty, sends the pair in the frame that starts at that boundary. This does not set `underrun`, and the holding entry stays empty.
- R11: At a frame boundary with no pair held and no handshake, the previous pair is sent again and `underrun` is set. `underrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 3 | Frame format code, taken at frame boundary |
| wlen_sel | input | 2 | Word length code, taken at frame boundary |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit holding entry empty |
| tx_left | input | 24 | Slot 0 transmit sample, right-aligned |
| tx_right | input | 24 | Slot 1 transmit sample, right-aligned |
| rx_ready | input | 1 | Host takes the received pair |
| rx_valid | output | 1 | Received pair present |
| rx_left | output | 24 | Slot 0 received sample, right-aligned |
| rx_right | output | 24 | Slot 1 received sample, right-aligned |
| bclk | output | 1 | Bit clock to the codec |
| fclk | output | 1 | Frame clock or frame sync to the codec |
| sdout | output | 1 | Serial data to the codec |
| sdin | input | 1 | Serial data from the codec |
| underrun | output | 1 | Sticky: a frame repeated its pair |

## Verification
Two things can happen in the same master-clock cycle: the host's transmit handshake and the frame-boundary load that moves a pair into the serializer. The bench provokes this by offering a pair in exactly the cycle whose edge ends a frame, while the holding entry is empty. It then expects that pair in the frame just starting, `underrun` still low and `tx_ready` still high afterwards. In the same cycle it also raises `rx_ready`, so that taking the received pair coincides with the boundary. In the next frame it offers nothing and expects the same pair to be repeated with `underrun` set.

// File: rtl/sap_pkg.sv
`timescale 1ns/1ps
package sap_pkg;

    typedef enum logic [2:0] {
        FMT_I2S       = 3'd0,
        FMT_LJ        = 3'd1,
        FMT_RJ        = 3'd2,
        FMT_TDM_LVL   = 3'd3,
        FMT_TDM_PULSE = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_18 = 2'd1,
        WL_20 = 2'd2,
        WL_24 = 2'd3
    } wlen_e;

    typedef struct packed {
        fmt_e  fmt;
        wlen_e wlen;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{fmt: FMT_I2S, wlen: WL_24};

    function automatic cfg_t decode_cfg(input logic [2:0] f, input logic [1:0] w);
        cfg_t c;
        c.wlen = wlen_e'(w);
        c.fmt  = (f > 3'd4) ? FMT_I2S : fmt_e'(f);
        return c;
    endfunction

    function automatic int word_bits(input wlen_e w);
        case (w)
            WL_16:   return 16;
            WL_18:   return 18;
            WL_20:   return 20;
            default: return 24;
        endcase
    endfunction

    // slot position of the MSB
    function automatic int data_start(input cfg_t c, input int slot_bits);
        case (c.fmt)
            FMT_I2S: return 1;
            FMT_RJ:  return slot_bits - word_bits(c.wlen);
            default: return 0;
        endcase
    endfunction

    function automatic logic frame_level(input cfg_t c, input int k, input int slot_bits);
        case (c.fmt)
            FMT_I2S:       return k >= slot_bits;
            FMT_TDM_PULSE: return k == 2 * slot_bits - 1;
            default:       return k < slot_bits;
        endcase
    endfunction

endpackage

// File: rtl/sap_clkgen.sv
`timescale 1ns/1ps
module sap_clkgen
    import sap_pkg::*;
#(
    parameter int MCLK_PER_BIT = 4,
    parameter int FRAME_BITS   = 64,
    parameter int BIT_W        = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_in,
    output cfg_t             cfg_q,
    output logic             bclk,
    output logic [BIT_W-1:0] bit_idx,
    output logic             fall_stb,
    output logic             rise_stb,
    output logic             frame_end
);
    localparam int DIV_W = (MCLK_PER_BIT > 2) ? $clog2(MCLK_PER_BIT) : 1;
    localparam int HALF  = MCLK_PER_BIT / 2;

    logic [DIV_W-1:0] div;

    assign fall_stb  = (div == DIV_W'(MCLK_PER_BIT - 1));
    assign rise_stb  = (div == DIV_W'(HALF - 1));
    assign frame_end = fall_stb && (bit_idx == BIT_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div     <= '0;
            bit_idx <= '0;
            bclk    <= 1'b0;
            cfg_q   <= CFG_RESET;
        end else begin
            div <= fall_stb ? '0 : div + 1'b1;
            if (rise_stb) bclk <= 1'b1;
            if (fall_stb) begin
                bclk    <= 1'b0;
                bit_idx <= frame_end ? '0 : bit_idx + 1'b1;
            end
            if (frame_end) cfg_q <= cfg_in;
        end
    end

    p_bit_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(bit_idx) |-> $fell(bclk));

endmodule

// File: rtl/sap_tx.sv
`timescale 1ns/1ps
module sap_tx
    import sap_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24,
    parameter int BIT_W     = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall_stb,
    input  logic                frame_end,
    input  logic [BIT_W-1:0]    bit_idx,
    input  cfg_t                cfg_in,
    input  cfg_t                cfg_q,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                sdout,
    output logic                fclk,
    output logic                underrun
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;

    logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r, nxt_l, nxt_r, word;
    logic                full, take, bit_n;
    cfg_t                cfg_n;
    int                  k_n, pos, wb, st;

    assign tx_ready = !full;
    assign take     = tx_valid && !full;

    always_comb begin
        cfg_n = frame_end ? cfg_in : cfg_q;
        nxt_l = act_l;
        nxt_r = act_r;
        if (frame_end) begin
            if (full) begin
                nxt_l = hold_l;
                nxt_r = hold_r;
            end else if (take) begin
                nxt_l = tx_left;
                nxt_r = tx_right;
            end
        end
        k_n   = frame_end ? 0 : int'(bit_idx) + 1;
        pos   = k_n % SLOT_BITS;
        word  = (k_n >= SLOT_BITS) ? nxt_r : nxt_l;
        wb    = word_bits(cfg_n.wlen);
        st    = data_start(cfg_n, SLOT_BITS);
        bit_n = 1'b0;
        if (pos >= st && pos < st + wb) bit_n = word[wb - 1 - (pos - st)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l   <= '0;
            hold_r   <= '0;
            act_l    <= '0;
            act_r    <= '0;
            full     <= 1'b0;
            underrun <= 1'b0;
            sdout    <= 1'b0;
            fclk     <= frame_level(CFG_RESET, 0, SLOT_BITS);
        end else begin
            if (frame_end) begin
                full <= 1'b0;
                if (!full && !take) underrun <= 1'b1;
            end else if (take) begin
                full   <= 1'b1;
                hold_l <= tx_left;
                hold_r <= tx_right;
            end
            if (fall_stb) begin
                act_l <= nxt_l;
                act_r <= nxt_r;
                sdout <= bit_n;
                fclk  <= frame_level(cfg_n, k_n, SLOT_BITS);
            end
        end
    end

    p_ready_drops_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !frame_end) |=> !tx_ready);

    p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    p_sdout_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        !fall_stb |=> $stable(sdout) && $stable(fclk));

    p_pulse_last_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.fmt == FMT_TDM_PULSE && fclk) |-> bit_idx == BIT_W'(FRAME_BITS - 1));

endmodule

// File: rtl/sap_rx.sv
`timescale 1ns/1ps
module sap_rx
    import sap_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24,
    parameter int BIT_W     = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rise_stb,
    input  logic [BIT_W-1:0]    bit_idx,
    input  cfg_t                cfg_q,
    input  logic                sdin,
    input  logic                rx_ready,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;

    logic [SAMPLE_W-1:0] sh_l, sh_r, base, shifted;
    logic                slot1, in_win, last;
    int                  pos, wb, st;

    always_comb begin
        slot1   = int'(bit_idx) >= SLOT_BITS;
        pos     = int'(bit_idx) % SLOT_BITS;
        wb      = word_bits(cfg_q.wlen);
        st      = data_start(cfg_q, SLOT_BITS);
        in_win  = (pos >= st) && (pos < st + wb);
        base    = (pos == 0) ? '0 : (slot1 ? sh_r : sh_l);
        shifted = in_win ? {base[SAMPLE_W-2:0], sdin} : base;
        last    = rise_stb && (bit_idx == BIT_W'(FRAME_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_l     <= '0;
            sh_r     <= '0;
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (rise_stb) begin
                if (slot1) sh_r <= shifted;
                else       sh_l <= shifted;
            end
            if (last) begin
                rx_left  <= sh_l;
                rx_right <= shifted;
                rx_valid <= 1'b1;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready && !last) |=> rx_valid && $stable(rx_left) && $stable(rx_right));

    p_rx_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(bit_idx) == BIT_W'(FRAME_BITS - 1));

endmodule

// File: rtl/audio_serial_port.sv
`timescale 1ns/1ps
module audio_serial_port
    import sap_pkg::*;
#(
    parameter int MCLK_PER_BIT = 4,
    parameter int SLOT_BITS    = 32,
    parameter int SAMPLE_W     = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                rx_ready,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                bclk,
    output logic                fclk,
    output logic                sdout,
    input  logic                sdin,
    output logic                underrun
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    cfg_t             cfg_in, cfg_q;
    logic [BIT_W-1:0] bit_idx;
    logic             fall_stb, rise_stb, frame_end;

    assign cfg_in = decode_cfg(fmt_sel, wlen_sel);

    sap_clkgen #(
        .MCLK_PER_BIT(MCLK_PER_BIT),
        .FRAME_BITS  (FRAME_BITS),
        .BIT_W       (BIT_W)
    ) u_clk (
        .clk      (clk),
        .rst      (rst),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q),
        .bclk     (bclk),
        .bit_idx  (bit_idx),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .frame_end(frame_end)
    );

    sap_tx #(
        .SLOT_BITS(SLOT_BITS),
        .SAMPLE_W (SAMPLE_W),
        .BIT_W    (BIT_W)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .fall_stb (fall_stb),
        .frame_end(frame_end),
        .bit_idx  (bit_idx),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .sdout    (sdout),
        .fclk     (fclk),
        .underrun (underrun)
    );

    sap_rx #(
        .SLOT_BITS(SLOT_BITS),
        .SAMPLE_W (SAMPLE_W),
        .BIT_W    (BIT_W)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rise_stb(rise_stb),
        .bit_idx (bit_idx),
        .cfg_q   (cfg_q),
        .sdin    (sdin),
        .rx_ready(rx_ready),
        .rx_valid(rx_valid),
        .rx_left (rx_left),
        .rx_right(rx_right)
    );

endmodule

// File: tb/audio_serial_port_test.sv
`timescale 1ns/1ps
module audio_serial_port_test;

    localparam int NV = 9;
    // {fmt[2:0], wlen[1:0], tx_l, tx_r, rx_l, rx_r}
    localparam logic [100:0] VEC [NV] = '{
        {3'd0, 2'd3, 24'hA5C3E1, 24'h1E3C5A, 24'h7F0081, 24'h80FF7E},
        {3'd1, 2'd0, 24'hFFBEEF, 24'h00CAFE, 24'h001234, 24'h00FEDC},
        {3'd2, 2'd1, 24'h02A5A5, 24'hF15A5A, 24'h03C0DE, 24'h00F00D},
        {3'd3, 2'd2, 24'h0ABCDE, 24'h0FEDCB, 24'h012345, 24'h09876A},
        {3'd4, 2'd3, 24'h800001, 24'h7FFFFE, 24'hC0FFEE, 24'h3D2B19},
        {3'd0, 2'd0, 24'h00F0F0, 24'hAB0F0F, 24'h00AAAA, 24'h005555},
        {3'd2, 2'd3, 24'h123456, 24'h654321, 24'hFEDCBA, 24'h0BADF0},
        {3'd4, 2'd1, 24'h02FFFF, 24'h010000, 24'h01F0F0, 24'h020F0F},
        {3'd1, 2'd2, 24'h0C3C3C, 24'h03C3C3, 24'h0DEAD1, 24'h0BEEF2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt_sel = 3'd0;
    logic [1:0]  wlen_sel = 2'd3;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [23:0] tx_left = '0, tx_right = '0;
    logic        rx_ready = 1'b0;
    logic        rx_valid;
    logic [23:0] rx_left, rx_right;
    logic        bclk, fclk, sdout;
    logic        sdin = 1'b0;
    logic        underrun;

    int ecnt   = 0;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    audio_serial_port uut (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
        .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right),
        .bclk(bclk), .fclk(fclk), .sdout(sdout), .sdin(sdin), .underrun(underrun)
    );

    always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

    function automatic int nbits(input logic [1:0] wl);
        case (wl)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic int first_pos(input logic [2:0] fm, input int w);
        if (fm == 3'd2) return 32 - w;
        if (fm == 3'd1 || fm == 3'd3 || fm == 3'd4) return 0;
        return 1;
    endfunction

    function automatic logic ser_bit(input logic [2:0] fm, input logic [1:0] wl, input int k,
                                     input logic [23:0] l, input logic [23:0] r, input logic pad);
        int p, w, o;
        logic [23:0] wd;
        p  = k % 32;
        wd = (k >= 32) ? r : l;
        w  = nbits(wl);
        o  = first_pos(fm, w);
        if (p >= o && p < o + w) return wd[w - 1 - (p - o)];
        return pad;
    endfunction

    function automatic logic exp_fclk(input logic [2:0] fm, input int k);
        if (fm == 3'd4) return k == 63;
        if (fm == 3'd1 || fm == 3'd2 || fm == 3'd3) return k < 32;
        return k >= 32;
    endfunction

    // codec model: new bit just after each falling bit-clock edge, ones outside the word
    always @(negedge clk) begin
        if (!rst && (ecnt % 4 == 0)) begin
            int f, k;
            f = ecnt / 256;
            k = (ecnt / 4) % 64;
            if (f >= 1 && f <= NV)
                sdin <= ser_bit(VEC[f-1][100:98], VEC[f-1][97:96], k,
                                VEC[f-1][47:24], VEC[f-1][23:0], 1'b1);
            else
                sdin <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_at(input int n);
        while (ecnt < n) @(negedge clk);
    endtask

    task automatic push(input logic [2:0] fm, input logic [1:0] wl,
                        input logic [23:0] l, input logic [23:0] r);
        fmt_sel  = fm;
        wlen_sel = wl;
        tx_left  = l;
        tx_right = r;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check("R9 tx_ready low while entry held", 64'(tx_ready), 64'd0);
    endtask

    task automatic run_frame(input int f, input logic [2:0] fm, input logic [1:0] wl,
                             input logic [23:0] l, input logic [23:0] r,
                             input bit do_push, input int nidx);
        logic [63:0] gd, gf, ed, ef, bh, bl;
        string dtag, ftag;
        for (int k = 0; k < 64; k++) begin
            wait_at(256 * f + 4 * k);
            bl[63-k] = bclk;
            wait_at(256 * f + 4 * k + 2);
            bh[63-k] = bclk;
            gd[63-k] = sdout;
            gf[63-k] = fclk;
            ed[63-k] = ser_bit(fm, wl, k, l, r, 1'b0);
            ef[63-k] = exp_fclk(fm, k);
            if (k == 0 && do_push)
                push(VEC[nidx][100:98], VEC[nidx][97:96], VEC[nidx][95:72], VEC[nidx][71:48]);
        end
        if (fm == 3'd2)                      dtag = "R5/R7 right-justified data";
        else if (fm == 3'd1 || fm == 3'd3)   dtag = "R4/R7 MSB-aligned data";
        else if (fm == 3'd4)                 dtag = "R4/R7 pulse-TDM data";
        else                                 dtag = "R3/R7 I2S data";
        ftag = (fm == 3'd4) ? "R6 pulse sync" : "R2 frame clock level";
        check(dtag, gd, ed);
        check(ftag, gf, ef);
        check("R1 bit clock high half", bh, {64{1'b1}});
        check("R1 bit clock low half", bl, 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [23:0] m;
        int w;
        repeat (5) @(negedge clk);
        check("R1 reset bclk", 64'(bclk), 64'd0);
        check("R1 reset fclk", 64'(fclk), 64'd0);
        check("R1 reset sdout", 64'(sdout), 64'd0);
        check("R1 reset tx_ready", 64'(tx_ready), 64'd1);
        check("R1 reset rx_valid", 64'(rx_valid), 64'd0);
        check("R1 reset underrun", 64'(underrun), 64'd0);
        rst = 1'b0;

        push(VEC[0][100:98], VEC[0][97:96], VEC[0][95:72], VEC[0][71:48]);

        for (int i = 0; i < NV; i++) begin
            int f;
            f = i + 1;
            run_frame(f, VEC[i][100:98], VEC[i][97:96], VEC[i][95:72], VEC[i][71:48],
                      (i < NV - 1), i + 1);
            wait_at(256 * f + 255);
            w = nbits(VEC[i][97:96]);
            m = 24'((32'h1 << w) - 1);
            check("R8 rx_valid after last bit", 64'(rx_valid), 64'd1);
            check("R8 rx_left word", 64'(rx_left), 64'(VEC[i][47:24] & m));
            check("R8 rx_right word", 64'(rx_right), 64'(VEC[i][23:0] & m));
            rx_ready = 1'b1;
            if (i == NV - 1) begin
                // R10: offer a pair in the boundary cycle with the entry empty
                fmt_sel  = 3'd1;
                wlen_sel = 2'd3;
                tx_left  = 24'h5EC0DE;
                tx_right = 24'hA13F21;
                tx_valid = 1'b1;
            end
            @(negedge clk);
            rx_ready = 1'b0;
            tx_valid = 1'b0;
            check("R8 rx_valid cleared by rx_ready", 64'(rx_valid), 64'd0);
            if (i == NV - 1)
                check("R10 entry still empty after boundary handshake", 64'(tx_ready), 64'd1);
        end
        check("R11 no underrun while fed", 64'(underrun), 64'd0);

        run_frame(NV + 1, 3'd1, 2'd3, 24'h5EC0DE, 24'hA13F21, 1'b0, 0);
        check("R10 boundary handshake sets no underrun", 64'(underrun), 64'd0);

        run_frame(NV + 2, 3'd1, 2'd3, 24'h5EC0DE, 24'hA13F21, 1'b0, 0);
        check("R11 underrun set after missed frame", 64'(underrun), 64'd1);
        wait_at(256 * (NV + 3) + 8);
        check("R11 underrun stays set", 64'(underrun), 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule